// File: doc/BRIEF.md
# Packed SIMD Greater-Than Comparator

This unit compares two packed vector operands lane by lane and returns a lane-wide mask for each lane. The mask is all ones where the lane of the first operand is strictly greater than the matching lane of the second operand. It is all zeros in every other case. The lane width is chosen at run time as 8, 16 or 32 bits. Integer lanes are read as signed two's complement or as unsigned values. A separate mode reads 32-bit lanes as single-precision floating-point values.

A wide mode compares all 128 bits. A narrow mode compares only the low 64 bits. The unit also checks the operation's encoding fields, the size code and the three register indices, against the rules for legal combinations. When the encoding is illegal it raises an undefined-operation flag and produces no result. Each operation is sampled on a clock edge when `in_valid` is high. Its outputs appear one cycle later.

Top module: `simd_gt_unit`

## Requirements
- R1: A result lane is all ones when the first operand lane is strictly greater than the second, and all zeros otherwise, including when the two lanes are equal.
- R2: With float mode clear, the size code gives the lane width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits. Each result lane has the same width and position as its operand lanes.
- R3: With `is_unsigned` = 1 integer lanes compare as unsigned values. With `is_unsigned` = 0 they compare as signed two's-complement values.
- R4: With `fmode` = 1 every 32-bit lane is an IEEE single-precision value (bit 31 sign, bits 30:23 exponent, bits 22:0 fraction) compared numerically. The size code and `is_unsigned` have no effect, except that size 2'b11 is still illegal.
- R5: In float mode, a lane where either input is a NaN (exponent all ones, fraction non-zero) gives all zeros.
- R6: In float mode, +0 and -0 compare as equal, so either order gives all zeros.
- R7: A size code of 2'b11 with `in_valid` high raises `undef_op` one cycle later.
- R8: With `quad` = 1, any of `idx_d`, `idx_n`, `idx_m` having bit 0 set raises `undef_op`. With `quad` = 0, odd indices are legal.
- R9: With `quad` = 0 only operand bits 63:0 are compared. Result bits 127:64 are zero and the upper operand bits have no effect.
- R10: When `undef_op` is high the result is zero and `res_valid` is low. When no operation was issued, all three outputs are low.
- R11: Outputs are registered. They reflect the operation sampled on the previous rising edge, and they are all zero while the synchronous active-low reset is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| quad | input | 1 | 1 = 128-bit operands, 0 = 64-bit |
| fmode | input | 1 | 1 = single-precision float lanes |
| is_unsigned | input | 1 | 1 = unsigned integer compare |
| size | input | 2 | Lane size code |
| idx_d | input | 5 | Destination register index (legality only) |
| idx_n | input | 5 | First source register index (legality only) |
| idx_m | input | 5 | Second source register index (legality only) |
| opa | input | 128 | First operand |
| opb | input | 128 | Second operand |
| result | output | 128 | Lane masks |
| res_valid | output | 1 | Legal result present |
| undef_op | output | 1 | Illegal encoding seen |

## Verification
The datapath holds no state across operations. A wrong lane selection, a wrong sign treatment or a wrong float decode therefore shows in the `result` mask one cycle after the operation is issued. It does not build up over time. The bench sets each lane width, both signedness settings and float mode against boundary operands. A slip in the sign-bit handling or the lane grouping then flips specific lanes that the bench can point to. An error in the legality decode shows in the same cycle as a wrong `undef_op` or `res_valid`, together with a result that is either non-zero or zero when it should not be.

// File: rtl/simd_gt_pkg.sv
// Shared widths and the lane-size code for the packed greater-than unit.
// Assumes the vector width is a multiple of twice the chunk width.
package simd_gt_pkg;
    parameter int VEC_W   = 128;
    parameter int CHUNK_W = 32;
    parameter int IDX_W   = 5;

    typedef enum logic [1:0] {
        LANE_B8   = 2'b00,
        LANE_H16  = 2'b01,
        LANE_W32  = 2'b10,
        LANE_BAD  = 2'b11
    } lane_sz_e;
endpackage

// File: rtl/gt_legal_chk.sv
// Encoding legality decode. Flags a reserved size code, and odd register
// indices when the wide (quad) mode is selected. Purely combinational.
module gt_legal_chk
    import simd_gt_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic          quad,
    input  logic [1:0]    size,
    input  logic [IW-1:0] idx_d,
    input  logic [IW-1:0] idx_n,
    input  logic [IW-1:0] idx_m,
    output logic          illegal
);
    logic bad_size;
    logic bad_pair;

    // Decode the two illegal conditions and merge them.
    always_comb begin
        bad_size = (lane_sz_e'(size) == LANE_BAD);
        bad_pair = quad && (idx_d[0] || idx_n[0] || idx_m[0]);
        illegal  = bad_size || bad_pair;
    end
endmodule

// File: rtl/gt_int_chunk.sv
// Integer greater-than over one chunk. Builds masks for every lane width
// in parallel and selects one by the size code. A signed compare is made
// unsigned by inverting each lane's top bit. Reserved size gives zero.
module gt_int_chunk
    import simd_gt_pkg::*;
#(
    parameter int CW = CHUNK_W
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    input  logic          uns,
    input  logic [1:0]    size,
    output logic [CW-1:0] mask
);
    localparam int NW = 3;
    logic [CW-1:0] per_w [NW];

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int LW = 8 << g;
        localparam int NL = CW / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            logic [LW-1:0] ka;
            logic [LW-1:0] kb;
            // Bias the lane keys so one unsigned compare serves both types.
            always_comb begin
                ka = a[l*LW +: LW];
                kb = b[l*LW +: LW];
                ka[LW-1] = ka[LW-1] ^ ~uns;
                kb[LW-1] = kb[LW-1] ^ ~uns;
            end
            assign per_w[g][l*LW +: LW] = {LW{ka > kb}};
        end
    end

    // Pick the mask set for the requested lane width.
    always_comb begin
        case (lane_sz_e'(size))
            LANE_B8:  mask = per_w[0];
            LANE_H16: mask = per_w[1];
            LANE_W32: mask = per_w[2];
            default:  mask = '0;
        endcase
    end
endmodule

// File: rtl/gt_fp_chunk.sv
// Single-precision ordered greater-than on one 32-bit lane. A NaN on
// either side gives false, and signed zeros are equal. Needs no rounding.
module gt_fp_chunk (
    input  logic [31:0] a,
    input  logic [31:0] b,
    output logic [31:0] mask
);
    logic a_nan, b_nan, both_zero, gt;

    // Classify the inputs, then order them by sign and magnitude.
    always_comb begin
        a_nan     = (a[30:23] == 8'hFF) && (a[22:0] != '0);
        b_nan     = (b[30:23] == 8'hFF) && (b[22:0] != '0);
        both_zero = (a[30:0] == '0) && (b[30:0] == '0);
        case ({a[31], b[31]})
            2'b00:   gt = a[30:0] > b[30:0];
            2'b11:   gt = a[30:0] < b[30:0];
            2'b01:   gt = 1'b1;
            default: gt = 1'b0;
        endcase
        if (a_nan || b_nan || both_zero) gt = 1'b0;
        mask = {32{gt}};
    end
endmodule

// File: rtl/simd_gt_unit.sv
// Packed vector greater-than with lane masks. Splits the operands into
// 32-bit chunks and runs an integer and a float compare on each. It picks
// one by mode, clears the upper half in narrow mode and registers the
// result. Assumes VEC_W is a multiple of 2*CHUNK_W.
module simd_gt_unit
    import simd_gt_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          quad,
    input  logic          fmode,
    input  logic          is_unsigned,
    input  logic [1:0]    size,
    input  logic [IW-1:0] idx_d,
    input  logic [IW-1:0] idx_n,
    input  logic [IW-1:0] idx_m,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    output logic [W-1:0]  result,
    output logic          res_valid,
    output logic          undef_op
);
    localparam int NCH    = W / CHUNK_W;
    localparam int NCH_LO = NCH / 2;

    logic         illegal;
    logic [W-1:0] next_res;

    gt_legal_chk #(.IW(IW)) i_legal (
        .quad    (quad),
        .size    (size),
        .idx_d   (idx_d),
        .idx_n   (idx_n),
        .idx_m   (idx_m),
        .illegal (illegal)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        logic [CHUNK_W-1:0] int_m;
        logic [CHUNK_W-1:0] fp_m;
        logic               live;

        gt_int_chunk #(.CW(CHUNK_W)) i_int (
            .a    (opa[k*CHUNK_W +: CHUNK_W]),
            .b    (opb[k*CHUNK_W +: CHUNK_W]),
            .uns  (is_unsigned),
            .size (size),
            .mask (int_m)
        );

        gt_fp_chunk i_fp (
            .a    (opa[k*CHUNK_W +: 32]),
            .b    (opb[k*CHUNK_W +: 32]),
            .mask (fp_m)
        );

        // Chunks in the upper half are only live in quad mode.
        assign live = (k < NCH_LO) || quad;
        assign next_res[k*CHUNK_W +: CHUNK_W] =
            !live ? '0 : (fmode ? fp_m : int_m);
    end

    // Register the masks and the status flags for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
            undef_op  <= 1'b0;
        end else begin
            result    <= (in_valid && !illegal) ? next_res : '0;
            res_valid <= in_valid && !illegal;
            undef_op  <= in_valid && illegal;
        end
    end
endmodule

// File: rtl/simd_gt_props.sv
// Property checker for simd_gt_unit, attached by bind. Watches the
// legality flags, output clearing and narrow-mode upper-half zeroing.
module simd_gt_props #(
    parameter int W  = 128,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          quad,
    input logic [1:0]    size,
    input logic [IW-1:0] idx_d,
    input logic [IW-1:0] idx_n,
    input logic [IW-1:0] idx_m,
    input logic [W-1:0]  result,
    input logic          res_valid,
    input logic          undef_op
);
    // R7
    size_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'b11) |=> undef_op);

    // R8
    quad_odd_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && quad && (idx_d[0] || idx_n[0] || idx_m[0])) |=> undef_op);

    // R10
    undef_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |-> (result == '0 && !res_valid));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> result == '0);

    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result[W-1:W/2] != '0) |-> $past(quad));

    // R11
    issue_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !undef_op));
endmodule

bind simd_gt_unit simd_gt_props #(.W(W), .IW(IW)) i_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .quad      (quad),
    .size      (size),
    .idx_d     (idx_d),
    .idx_n     (idx_n),
    .idx_m     (idx_m),
    .result    (result),
    .res_valid (res_valid),
    .undef_op  (undef_op)
);

// File: tb/test_simd_gt_unit.sv
// Directed bench for simd_gt_unit. One task per scenario. Expected values
// come from a lane-by-lane reference model built from the requirements.
module test_simd_gt_unit;
    localparam int CLK_P = 10;
    localparam int W     = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          quad = 1'b0;
    logic          fmode = 1'b0;
    logic          is_unsigned = 1'b0;
    logic [1:0]    size = 2'b00;
    logic [4:0]    idx_d = '0;
    logic [4:0]    idx_n = '0;
    logic [4:0]    idx_m = '0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [W-1:0]  result;
    logic          res_valid;
    logic          undef_op;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    simd_gt_unit i_simd_gt_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .quad(quad),
        .fmode(fmode), .is_unsigned(is_unsigned), .size(size),
        .idx_d(idx_d), .idx_n(idx_n), .idx_m(idx_m),
        .opa(opa), .opb(opb), .result(result),
        .res_valid(res_valid), .undef_op(undef_op)
    );

    // Reference: numeric value of a single-precision bit pattern.
    function automatic real fp_val(input logic [31:0] x);
        real mag;
        int  e;
        e = int'(x[30:23]);
        if (e == 255)    mag = 1.0e300;
        else if (e == 0) mag = real'(x[22:0]) * (2.0 ** -149);
        else             mag = (1.0 + real'(x[22:0]) / (2.0 ** 23)) * (2.0 ** (e - 127));
        return x[31] ? -mag : mag;
    endfunction

    function automatic bit fp_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    // Reference lane-by-lane result per the requirements.
    function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic q, input logic fm,
                                             input logic u, input logic [1:0] sz);
        logic [W-1:0] r;
        int lw, span;
        r = '0;
        lw   = fm ? 32 : (8 << sz);
        span = q ? W : W/2;
        for (int i = 0; i < span / lw; i++) begin
            logic [31:0] ea, eb;
            longint sa, sb;
            bit gt;
            ea = 32'(a >> (i*lw));
            eb = 32'(b >> (i*lw));
            if (lw < 32) begin
                ea = ea & ((32'd1 << lw) - 1);
                eb = eb & ((32'd1 << lw) - 1);
            end
            if (fm) begin
                gt = !fp_nan(ea) && !fp_nan(eb) && (fp_val(ea) > fp_val(eb));
            end else begin
                sa = longint'(ea);
                sb = longint'(eb);
                if (!u && ea[lw-1]) sa = sa - (64'sd1 <<< lw);
                if (!u && eb[lw-1]) sb = sb - (64'sd1 <<< lw);
                gt = sa > sb;
            end
            for (int j = 0; j < lw; j++) r[i*lw + j] = gt;
        end
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation, then check the registered outputs a cycle later.
    task automatic run_op(input string req, input logic q, input logic fm, input logic u,
                          input logic [1:0] sz, input logic [4:0] d, input logic [4:0] n,
                          input logic [4:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
        bit bad;
        logic [W-1:0] exp;
        @(negedge clk);
        in_valid = 1'b1; quad = q; fmode = fm; is_unsigned = u; size = sz;
        idx_d = d; idx_n = n; idx_m = m; opa = a; opb = b;
        bad = (sz == 2'b11) || (q && (d[0] || n[0] || m[0]));
        exp = bad ? '0 : ref_res(a, b, q, fm, u, sz);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", result, exp);
        check(req, "res_valid", W'(res_valid), W'(!bad));
        check(req, "undef_op", W'(undef_op), W'(bad));
    endtask

    task automatic t_reset();
        // R11: outputs are zero under reset.
        check("R11", "reset result", result, '0);
        check("R11", "reset valid", W'(res_valid), '0);
        check("R11", "reset undef", W'(undef_op), '0);
    endtask

    task automatic t_int_widths();
        // R1 R2 R3: boundaries per lane width, both signedness settings.
        for (int s = 0; s < 3; s++) begin
            for (int u = 0; u < 2; u++) begin
                run_op("R2", 1'b1, 1'b0, 1'(u), 2'(s), 5'd0, 5'd2, 5'd4,
                       {16{8'h80}}, {16{8'h7F}});
                run_op("R3", 1'b1, 1'b0, 1'(u), 2'(s), 5'd0, 5'd2, 5'd4,
                       {32{4'hF}}, {16{8'h01}});
                run_op("R1", 1'b1, 1'b0, 1'(u), 2'(s), 5'd0, 5'd2, 5'd4,
                       128'h8000_7FFF_0000_FFFF_1234_5678_80FF_7F00,
                       128'h8000_7FFF_0000_FFFF_1234_5678_80FF_7F00);
                for (int k = 0; k < 6; k++)
                    run_op("R2", 1'b1, 1'b0, 1'(u), 2'(s), 5'd6, 5'd8, 5'd10,
                           {$urandom, $urandom, $urandom, $urandom},
                           {$urandom, $urandom, $urandom, $urandom});
            end
        end
    endtask

    task automatic t_float();
        // R4: ordinary ordering, size/unsigned ignored; R5 NaN; R6 signed zeros.
        run_op("R4", 1'b1, 1'b1, 1'b1, 2'b00, 5'd0, 5'd0, 5'd0,
               {32'h3F80_0000, 32'hBF80_0000, 32'hC000_0000, 32'h7F80_0000},
               {32'h3F00_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h7F7F_FFFF});
        run_op("R4", 1'b1, 1'b1, 1'b0, 2'b01, 5'd0, 5'd0, 5'd0,
               {32'h0000_0001, 32'h8000_0001, 32'hFF80_0000, 32'h4120_0000},
               {32'h0000_0000, 32'h0000_0000, 32'hFF7F_FFFF, 32'h4120_0000});
        run_op("R5", 1'b1, 1'b1, 1'b0, 2'b10, 5'd0, 5'd0, 5'd0,
               {32'h7FC0_0000, 32'h3F80_0000, 32'h7F80_0001, 32'hFFC0_0000},
               {32'h0000_0000, 32'h7FC0_0000, 32'hFF80_0000, 32'h3F80_0000});
        run_op("R6", 1'b1, 1'b1, 1'b0, 2'b10, 5'd0, 5'd0, 5'd0,
               {32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
               {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000});
    endtask

    task automatic t_undef();
        // R7 reserved size; R8 odd index in quad; R10 outputs cleared.
        run_op("R7", 1'b0, 1'b0, 1'b0, 2'b11, 5'd0, 5'd0, 5'd0, '1, '0);
        run_op("R7", 1'b1, 1'b1, 1'b0, 2'b11, 5'd0, 5'd0, 5'd0, '1, '0);
        run_op("R8", 1'b1, 1'b0, 1'b1, 2'b00, 5'd1, 5'd0, 5'd0, '1, '0);
        run_op("R8", 1'b1, 1'b0, 1'b1, 2'b00, 5'd0, 5'd3, 5'd0, '1, '0);
        run_op("R10", 1'b1, 1'b0, 1'b1, 2'b00, 5'd0, 5'd0, 5'd31, '1, '0);
        run_op("R8", 1'b0, 1'b0, 1'b1, 2'b00, 5'd1, 5'd3, 5'd5, '1, '0);
    endtask

    task automatic t_narrow();
        // R9: upper half zero, upper operand bits ignored.
        run_op("R9", 1'b0, 1'b0, 1'b1, 2'b00, 5'd0, 5'd0, 5'd0,
               {64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708},
               {64'h0, 64'h0807_0605_0403_0201});
        run_op("R9", 1'b0, 1'b1, 1'b0, 2'b10, 5'd0, 5'd0, 5'd0,
               {64'h3F80_0000_3F80_0000, 64'h3F80_0000_0000_0000},
               {64'h0, 64'h0000_0000_3F80_0000});
    endtask

    task automatic t_idle();
        // R10 R11: no issue means all outputs low on the next cycle.
        @(negedge clk);
        in_valid = 1'b0; opa = '1; opb = '0; size = 2'b11;
        @(negedge clk);
        check("R10", "idle result", result, '0);
        check("R11", "idle valid", W'(res_valid), '0);
        check("R11", "idle undef", W'(undef_op), '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_int_widths();
        t_float();
        t_undef();
        t_narrow();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule